// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index mark of an incremental rotary or linear encoder into a position count. Every edge on either phase moves the count by one, so a full quadrature cycle gives four counts. The count runs between 0 and a programmable ceiling and wraps at either end. A qualified index mark either clears the count or loads it with a preset value. The block also reports the direction of travel and gives single-cycle event pulses for direction reversals, rollovers and index loads in each direction, illegal phase steps, and a stalled encoder.

The phase and index inputs are expected to be debounced and synchronous to `clk` already. Configuration is taken from the `cfg_*` inputs only while `enable` is low. The block holds a frozen copy of these settings while it counts, so software can prepare the next setup at any time without disturbing the running count.

Top module: `qenc_position_counter`

## Requirements
- R1: While enabled, a single-phase change moves `count` by one on the next clock edge. It counts up when the decoded pair (A,B) steps 00→10→11→01→00 and down for the reverse order, so one full cycle gives four counts.
- R2: A step up with `count` equal to the frozen ceiling loads 0 and pulses `evt_rst_up` for one cycle.
- R3: A step down with `count` equal to 0 loads the frozen ceiling and pulses `evt_rst_dn` for one cycle.
- R4: With `cfg_swap` = 1, phase A and phase B trade roles before decoding, so the pin sequence that counts up without swap counts down.
- R5: A sample in which both decoded phases differ from the previous sample is illegal. It leaves `count` and `dir_up` unchanged and pulses `evt_phase_err` for one cycle.
- R6: `dir_up` (1 = up, 0 = down) follows the last legal step. `evt_dir` pulses for one cycle when a legal step goes the other way from `dir_up`.
- R7: An index event is the rising edge of `enc_index` AND ({decoded A, decoded B} == `cfg_gate`): code 0 = A low B low, 1 = A low B high, 2 = A high B low, 3 = A high B high. An index high outside the gated levels does nothing. With `cfg_rst_on_index` = 1, an index event clears `count`. It pulses `evt_rst_up` if `dir_up` is 1, otherwise `evt_rst_dn`, and it takes priority over a step in the same cycle.
- R8: With `cfg_rst_on_index` = 0, an index event loads the frozen preset value into `count`, with the same event pulse as R7.
- R9: Configuration inputs are captured only while `enable` is 0. Changes made while it is 1 have no effect on counting.
- R10: With a nonzero frozen watchdog limit L, `evt_wdt` pulses once, L clock edges after the last legal step, if no legal step comes in between. A limit of 0 disables it.
- R11: While `enable` is 0, `count` and `dir_up` hold and no event pulses.
- R12: After reset, `count` is 0, `dir_up` is 1 and all event outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Counting enable; configuration is captured while low |
| cfg_ceiling | input | CNT_W | Upper wrap value |
| cfg_preset | input | CNT_W | Value loaded on index in preset mode |
| cfg_wdt_limit | input | WDT_W | Stall timeout in clock cycles, 0 = off |
| cfg_gate | input | 2 | Phase level pair that qualifies the index |
| cfg_swap | input | 1 | Exchange phase A and phase B |
| cfg_rst_on_index | input | 1 | 1 = clear on index, 0 = load preset on index |
| enc_a | input | 1 | Encoder phase A |
| enc_b | input | 1 | Encoder phase B |
| enc_index | input | 1 | Encoder index mark |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of the last legal step |
| evt_dir | output | 1 | Direction reversal pulse |
| evt_rst_up | output | 1 | Rollover or index load while counting up |
| evt_rst_dn | output | 1 | Rollover or index load while counting down |
| evt_wdt | output | 1 | Stall timeout pulse |
| evt_phase_err | output | 1 | Illegal two-phase step pulse |

## Verification
A stale previous-phase register shows up on the next step as a wrong count, a spurious `evt_phase_err` or a reversed `dir_up`, all within one clock of the pin change. A config copy that tracks the inputs while enabled shows up only at the next rollover, which moves to the new ceiling. The bench therefore forces a wrap right after changing the ceiling live. An index edge detector that misses the gate, or fires on the level instead of the edge, shows up as a count load one cycle after `enc_index` rises. A watchdog off by one shows up as `evt_wdt` one edge early or late, or repeated, so the bench samples each edge around the expected timeout.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
// Shared types for the quadrature position counter.
package qenc_pkg;
    // Result of comparing one decoded phase sample with the previous one.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_t;
endpackage

// File: rtl/qenc_cfg_hold.sv
`timescale 1ns/1ps
// Configuration shadow. Tracks the cfg inputs while the block is disabled
// and freezes them while it is enabled. Assumes cfg inputs are synchronous.
module qenc_cfg_hold #(
    parameter int CNT_W = 32,
    parameter int WDT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] in_ceiling,
    input  logic [CNT_W-1:0] in_preset,
    input  logic [WDT_W-1:0] in_wdt_limit,
    input  logic [1:0]       in_gate,
    input  logic             in_swap,
    input  logic             in_rst_on_index,
    output logic [CNT_W-1:0] ceiling,
    output logic [CNT_W-1:0] preset,
    output logic [WDT_W-1:0] wdt_limit,
    output logic [1:0]       gate,
    output logic             swap,
    output logic             rst_on_index
);
    // Capture settings only while counting is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ceiling      <= '1;
            preset       <= '0;
            wdt_limit    <= '0;
            gate         <= 2'd3;
            swap         <= 1'b0;
            rst_on_index <= 1'b1;
        end else if (!enable) begin
            ceiling      <= in_ceiling;
            preset       <= in_preset;
            wdt_limit    <= in_wdt_limit;
            gate         <= in_gate;
            swap         <= in_swap;
            rst_on_index <= in_rst_on_index;
        end
    end

    // R9: the frozen ceiling does not move while counting.
    p_frozen_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(ceiling));
    p_frozen_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable(rst_on_index) && $stable(swap));
endmodule

// File: rtl/qenc_phase_decode.sv
`timescale 1ns/1ps
// Phase decoder. Optionally swaps A and B, remembers the previous decoded
// pair and classifies each sample as no step, up, down or illegal.
// Assumes the pins are already filtered and synchronous to clk.
module qenc_phase_decode
    import qenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_a,
    input  logic  pin_b,
    input  logic  swap,
    output logic  ph_a,
    output logic  ph_b,
    output step_t step
);
    logic prev_a;
    logic prev_b;
    logic chg_a;
    logic chg_b;

    // Apply the optional phase swap.
    always_comb begin
        ph_a = swap ? pin_b : pin_a;
        ph_b = swap ? pin_a : pin_b;
    end

    // Remember the last decoded pair every cycle so enabling never sees a jump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= ph_a;
            prev_b <= ph_b;
        end
    end

    // Classify the transition; the up order is 00,10,11,01.
    always_comb begin
        chg_a = ph_a ^ prev_a;
        chg_b = ph_b ^ prev_b;
        if (chg_a && chg_b)
            step = STEP_BAD;
        else if (chg_a || chg_b)
            step = (prev_a == ph_b) ? STEP_UP : STEP_DOWN;
        else
            step = STEP_NONE;
    end
endmodule

// File: rtl/qenc_index_gate.sv
`timescale 1ns/1ps
// Index qualifier. Accepts the index mark only while the decoded phases sit
// at the selected level pair, and reports one event per rising edge.
module qenc_index_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_pin,
    input  logic       ph_a,
    input  logic       ph_b,
    input  logic [1:0] gate,
    output logic       idx_evt
);
    logic qual;
    logic qual_q;

    // Gate code bit 1 is the A level, bit 0 the B level.
    always_comb qual = idx_pin && ({ph_a, ph_b} == gate);

    // Delay the qualified level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) qual_q <= 1'b0;
        else        qual_q <= qual;
    end

    always_comb idx_evt = qual && !qual_q;

    // R7: a held index gives a single event.
    p_index_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        idx_evt |=> !idx_evt);
endmodule

// File: rtl/qenc_watchdog.sv
`timescale 1ns/1ps
// Stall timer. Counts cycles since the last legal step while running and
// pulses once when the count reaches the limit. Limit 0 turns it off.
module qenc_watchdog #(
    parameter int WDT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             kick,
    input  logic [WDT_W-1:0] limit,
    output logic             timeout
);
    localparam logic [WDT_W-1:0] ONE = WDT_W'(1);
    logic [WDT_W-1:0] idle;

    // Advance the idle timer and flag the cycle it reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            idle    <= '0;
            timeout <= 1'b0;
        end else if (kick) begin
            idle    <= '0;
            timeout <= 1'b0;
        end else if (limit != '0 && idle != limit) begin
            idle    <= idle + ONE;
            timeout <= (idle + ONE == limit);
        end else begin
            timeout <= 1'b0;
        end
    end

    // R10: the timeout is a single pulse.
    p_wdt_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
endmodule

// File: rtl/qenc_position_counter.sv
`timescale 1ns/1ps
// Quadrature position counter top. Decodes four counts per encoder cycle,
// wraps between 0 and a ceiling, clears or presets on a gated index, and
// raises event pulses. Assumes pins are filtered and synchronous to clk.
module qenc_position_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int WDT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] cfg_ceiling,
    input  logic [CNT_W-1:0] cfg_preset,
    input  logic [WDT_W-1:0] cfg_wdt_limit,
    input  logic [1:0]       cfg_gate,
    input  logic             cfg_swap,
    input  logic             cfg_rst_on_index,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_index,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             evt_dir,
    output logic             evt_rst_up,
    output logic             evt_rst_dn,
    output logic             evt_wdt,
    output logic             evt_phase_err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] ceil_s;
    logic [CNT_W-1:0] preset_s;
    logic [WDT_W-1:0] wdt_s;
    logic [1:0]       gate_s;
    logic             swap_s;
    logic             rmode_s;
    logic             ph_a;
    logic             ph_b;
    step_t            step;
    logic             idx_evt;
    logic             legal;
    logic             going_up;

    qenc_cfg_hold #(.CNT_W(CNT_W), .WDT_W(WDT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .in_ceiling(cfg_ceiling), .in_preset(cfg_preset),
        .in_wdt_limit(cfg_wdt_limit), .in_gate(cfg_gate),
        .in_swap(cfg_swap), .in_rst_on_index(cfg_rst_on_index),
        .ceiling(ceil_s), .preset(preset_s), .wdt_limit(wdt_s),
        .gate(gate_s), .swap(swap_s), .rst_on_index(rmode_s)
    );

    qenc_phase_decode u_dec (
        .clk(clk), .rst_n(rst_n), .pin_a(enc_a), .pin_b(enc_b),
        .swap(swap_s), .ph_a(ph_a), .ph_b(ph_b), .step(step)
    );

    qenc_index_gate u_idx (
        .clk(clk), .rst_n(rst_n), .idx_pin(enc_index), .ph_a(ph_a),
        .ph_b(ph_b), .gate(gate_s), .idx_evt(idx_evt)
    );

    qenc_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk(clk), .rst_n(rst_n), .run(enable), .kick(legal),
        .limit(wdt_s), .timeout(evt_wdt)
    );

    // Step qualifiers for the counter.
    always_comb begin
        legal    = enable && (step == STEP_UP || step == STEP_DOWN);
        going_up = (step == STEP_UP);
    end

    // Count, direction and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count         <= '0;
            dir_up        <= 1'b1;
            evt_dir       <= 1'b0;
            evt_rst_up    <= 1'b0;
            evt_rst_dn    <= 1'b0;
            evt_phase_err <= 1'b0;
        end else begin
            evt_dir       <= 1'b0;
            evt_rst_up    <= 1'b0;
            evt_rst_dn    <= 1'b0;
            evt_phase_err <= enable && (step == STEP_BAD);
            if (legal) begin
                dir_up  <= going_up;
                evt_dir <= (going_up != dir_up);
            end
            if (enable && idx_evt) begin
                count      <= rmode_s ? '0 : preset_s;
                evt_rst_up <= dir_up;
                evt_rst_dn <= !dir_up;
            end else if (legal && going_up) begin
                if (count == ceil_s) begin
                    count      <= '0;
                    evt_rst_up <= 1'b1;
                end else begin
                    count <= count + ONE;
                end
            end else if (legal) begin
                if (count == '0) begin
                    count      <= ceil_s;
                    evt_rst_dn <= 1'b1;
                end else begin
                    count <= count - ONE;
                end
            end
        end
    end

    // R2: an up step at the ceiling wraps to zero with the up event.
    p_wrap_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && step == STEP_UP && !idx_evt && count == ceil_s)
        |=> (count == '0) && evt_rst_up);
    // R3: a down step at zero wraps to the ceiling with the down event.
    p_wrap_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && step == STEP_DOWN && !idx_evt && count == '0)
        |=> (count == $past(ceil_s)) && evt_rst_dn);
    // R5: an illegal step leaves the count alone.
    p_bad_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_phase_err && !evt_rst_up && !evt_rst_dn) |-> $stable(count));
    // R6: a reversal pulse always goes with a changed direction.
    p_dir_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dir |-> !$stable(dir_up));
    // R11: nothing moves while disabled.
    p_hold_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(count) && $stable(dir_up) && !evt_rst_up && !evt_rst_dn);
endmodule

// File: tb/qenc_position_counter_test.sv
`timescale 1ns/1ps
// Directed bench for the quadrature position counter.
module qenc_position_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] cfg_ceiling = 32'd1000;
    logic [31:0] cfg_preset = '0;
    logic [31:0] cfg_wdt_limit = '0;
    logic [1:0]  cfg_gate = 2'd3;
    logic        cfg_swap = 1'b0;
    logic        cfg_rst_on_index = 1'b1;
    logic        enc_a = 1'b0;
    logic        enc_b = 1'b0;
    logic        enc_index = 1'b0;
    logic [31:0] count;
    logic        dir_up, evt_dir, evt_rst_up, evt_rst_dn, evt_wdt, evt_phase_err;

    int          vectors = 0;
    int          fails = 0;
    int          pos = 0;
    logic        exp_dir = 1'b1;
    logic [31:0] exp_cnt = '0;
    logic [31:0] exp_ceil = '0;

    qenc_position_counter uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_ceiling(cfg_ceiling), .cfg_preset(cfg_preset),
        .cfg_wdt_limit(cfg_wdt_limit), .cfg_gate(cfg_gate),
        .cfg_swap(cfg_swap), .cfg_rst_on_index(cfg_rst_on_index),
        .enc_a(enc_a), .enc_b(enc_b), .enc_index(enc_index),
        .count(count), .dir_up(dir_up), .evt_dir(evt_dir),
        .evt_rst_up(evt_rst_up), .evt_rst_dn(evt_rst_dn),
        .evt_wdt(evt_wdt), .evt_phase_err(evt_phase_err)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic lvl_a(input int p); return (p == 1 || p == 2); endfunction
    function automatic logic lvl_b(input int p); return (p == 2 || p == 3); endfunction

    // One physical step; live says the block should count it, up its direction.
    task automatic move(input bit fwd, input bit live, input bit up, input string tag);
        logic eu, ed, edir;
        eu = 0; ed = 0; edir = 0;
        pos = fwd ? (pos + 1) % 4 : (pos + 3) % 4;
        enc_a = lvl_a(pos);
        enc_b = lvl_b(pos);
        tick();
        if (live) begin
            edir = (up != exp_dir);
            exp_dir = up;
            if (up) begin
                if (exp_cnt == exp_ceil) begin exp_cnt = 0; eu = 1; end
                else exp_cnt = exp_cnt + 1;
            end else begin
                if (exp_cnt == 0) begin exp_cnt = exp_ceil; ed = 1; end
                else exp_cnt = exp_cnt - 1;
            end
        end
        chk({tag, " count"}, count, exp_cnt);
        chk({tag, " dir_up"}, {31'd0, dir_up}, {31'd0, exp_dir});
        chk({tag, " evt_dir"}, {31'd0, evt_dir}, {31'd0, edir});
        chk({tag, " evt_rst_up"}, {31'd0, evt_rst_up}, {31'd0, eu});
        chk({tag, " evt_rst_dn"}, {31'd0, evt_rst_dn}, {31'd0, ed});
        chk({tag, " evt_phase_err"}, {31'd0, evt_phase_err}, 32'd0);
    endtask

    task automatic configure(input logic [31:0] ceil, input logic [31:0] pre,
                             input logic [31:0] wdt, input logic [1:0] gate,
                             input logic swap, input logic rmode);
        enable = 1'b0;
        cfg_ceiling = ceil; cfg_preset = pre; cfg_wdt_limit = wdt;
        cfg_gate = gate; cfg_swap = swap; cfg_rst_on_index = rmode;
        tick(); tick();
        enable = 1'b1;
        exp_ceil = ceil;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R12 count", count, 32'd0);
        chk("R12 dir_up", {31'd0, dir_up}, 32'd1);
        chk("R12 events", {26'd0, evt_dir, evt_rst_up, evt_rst_dn, evt_wdt, evt_phase_err, 1'b0}, 32'd0);
    endtask

    task automatic t_count_x4();
        configure(32'd1000, 0, 0, 2'd3, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) move(1, 1, 1, "R1 up");
        chk("R1 two cycles", count, 32'd8);
    endtask

    task automatic t_reverse();
        for (int i = 0; i < 3; i++) move(0, 1, 0, "R6 down");
        chk("R6 after reverse", count, 32'd5);
    endtask

    task automatic t_illegal();
        pos = (pos + 2) % 4;
        enc_a = lvl_a(pos);
        enc_b = lvl_b(pos);
        tick();
        chk("R5 count held", count, exp_cnt);
        chk("R5 dir held", {31'd0, dir_up}, {31'd0, exp_dir});
        chk("R5 err pulse", {31'd0, evt_phase_err}, 32'd1);
        tick();
        chk("R5 err single", {31'd0, evt_phase_err}, 32'd0);
    endtask

    task automatic t_disabled();
        enable = 1'b0;
        tick();
        for (int i = 0; i < 3; i++) move(1, 0, 1, "R11 off");
        enable = 1'b1;
    endtask

    task automatic t_wrap();
        configure(32'd5, 0, 0, 2'd3, 1'b0, 1'b1);
        chk("R2 start", count, 32'd5);
        move(1, 1, 1, "R2 wrap up");
        move(0, 1, 0, "R3 wrap down");
    endtask

    task automatic t_frozen();
        cfg_ceiling = 32'd100;
        cfg_rst_on_index = 1'b0;
        tick();
        move(1, 1, 1, "R9 live write ignored");
        chk("R9 wrapped at old ceiling", count, 32'd0);
    endtask

    task automatic t_swap();
        configure(32'd5, 0, 0, 2'd3, 1'b1, 1'b1);
        move(1, 1, 0, "R4 swapped fwd");
        move(1, 1, 0, "R4 swapped fwd");
        chk("R4 count", count, 32'd4);
    endtask

    task automatic t_index();
        configure(32'd1000, 0, 0, 2'd3, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) move(1, 1, 1, "R7 pre");
        while (pos != 1) move(1, 1, 1, "R7 align");
        enc_index = 1'b1;
        tick();
        chk("R7 gated out count", count, exp_cnt);
        chk("R7 gated out event", {31'd0, evt_rst_up}, 32'd0);
        enc_index = 1'b0;
        tick();
        move(1, 1, 1, "R7 to gate");
        enc_index = 1'b1;
        tick();
        exp_cnt = 0;
        chk("R7 index clears", count, 32'd0);
        chk("R7 index up event", {31'd0, evt_rst_up}, 32'd1);
        chk("R7 no down event", {31'd0, evt_rst_dn}, 32'd0);
        tick();
        chk("R7 level does not repeat", {31'd0, evt_rst_up}, 32'd0);
        enc_index = 1'b0;
        tick();
    endtask

    task automatic t_preset();
        configure(32'd1000, 32'd3, 0, 2'd3, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) move(1, 1, 1, "R8 pre");
        chk("R8 before", count, 32'd4);
        enc_index = 1'b1;
        tick();
        exp_cnt = 3;
        chk("R8 preset loaded", count, 32'd3);
        chk("R8 event", {31'd0, evt_rst_up}, 32'd1);
        enc_index = 1'b0;
        tick();
    endtask

    task automatic t_watchdog();
        configure(32'd1000, 0, 32'd10, 2'd3, 1'b0, 1'b1);
        move(1, 1, 1, "R10 kick");
        for (int i = 1; i < 10; i++) begin
            tick();
            chk("R10 quiet", {31'd0, evt_wdt}, 32'd0);
        end
        tick();
        chk("R10 timeout", {31'd0, evt_wdt}, 32'd1);
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R10 single", {31'd0, evt_wdt}, 32'd0);
        end
    endtask

    initial begin
        tick();
        t_reset();
        t_count_x4();
        t_reverse();
        t_illegal();
        t_disabled();
        t_wrap();
        t_frozen();
        t_swap();
        t_index();
        t_preset();
        t_watchdog();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #4000000;
        vectors++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule